// File: doc/BRIEF.md
# Paged Memory Mapping Unit

This block sits between a 16-bit processor and a larger word-addressed memory. On each memory cycle it turns a 16-bit logical word address into a 20-bit physical word address. It also decides whether the processor is allowed to make that access. The physical space holds 256 pages of 4K words each.

The processor's current address-state value picks one of sixteen banks of page descriptors. The upper four address bits then choose one descriptor inside that bank. Each descriptor supplies three things: an 8-bit physical page number, a 4-bit lock and a write-protect flag.

The processor's 4-bit access key must equal the lock. A mismatch, or a write to a write-protected page, pulls an active-low fault output low. The fault output and the translated address appear together, one clock after the request, marked by a response strobe.

A key of zero means the processor is privileged. Descriptor loads through the configuration port take effect only in that state. The block also repeats the key and address-state values toward the rest of the system. An enable flag shows whether the current bus cycle belongs to this processor.

Top module: `page_map_unit`

## Requirements
- R1: After reset every descriptor holds page 0, lock 0 and writable, so a read with key 0 maps logical address L to physical address L[11:0] with no fault. While reset is held, `rsp_valid` is low and `prot_err_n` is high.
- R2: The descriptor used is selected by bank `cpu_state` and by slot `req_addr[15:12]`. The physical address upper bits `rsp_paddr[19:12]` equal that descriptor's page number.
- R3: `rsp_paddr[11:0]` equals `req_addr[11:0]` of the same request, unchanged.
- R4: A request presented with `req_valid` high at one clock edge gives `rsp_valid` high, together with its address and fault result, for exactly the following cycle. With no request, `rsp_valid` is low.
- R5: When `cpu_key` differs from the selected descriptor's lock, `prot_err_n` is low in the response cycle. The physical address is still produced.
- R6: A write request (`req_write` = 1) to a descriptor whose write-protect flag is 1 drives `prot_err_n` low. A read of the same page with a matching key does not.
- R7: `prot_err_n` is high in every cycle where `rsp_valid` is low.
- R8: A descriptor load (`cfg_we` = 1) is accepted only when `cpu_key` is 0. With any other key the load is ignored and the descriptor keeps its old contents.
- R9: A load written at a clock edge is used by requests at later edges. A request at the same edge as the load sees the old descriptor.
- R10: `stat_oe` follows `bus_own`. `key_out` and `state_out` carry `cpu_key` and `cpu_state` while `bus_own` is 1, and are 0 while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Memory cycle request |
| req_addr | input | 16 | Logical word address |
| req_write | input | 1 | 1 = write cycle |
| cpu_key | input | 4 | Processor access key (0 = privileged) |
| cpu_state | input | 4 | Address-state value selecting the descriptor bank |
| bus_own | input | 1 | Current bus cycle belongs to this processor |
| cfg_we | input | 1 | Descriptor load strobe |
| cfg_bank | input | 4 | Bank of descriptor to load |
| cfg_slot | input | 4 | Slot within bank to load |
| cfg_page | input | 8 | Physical page number to load |
| cfg_lock | input | 4 | Lock value to load |
| cfg_wprot | input | 1 | Write-protect flag to load |
| rsp_valid | output | 1 | Translation result strobe |
| rsp_paddr | output | 20 | Physical word address |
| prot_err_n | output | 1 | Active-low protection fault |
| stat_oe | output | 1 | Status outputs driven (otherwise released) |
| key_out | output | 4 | Key seen by the system |
| state_out | output | 4 | Address state seen by the system |

## Verification
Translation is exercised with the same slot index in two different banks and with two slots in one bank. This separates bank selection from slot selection. Offsets of all-zeros, all-ones and a mixed pattern show that the offset field is carried through without being touched.

The protection logic is tested with matching and non-matching keys, and with reads and writes to protected and unprotected pages. This separates the lock comparison from the write-protect check.

Two further tests cover ordering and privilege. A load from an unprivileged key is tried. A load and a request are issued in the same cycle, which shows that descriptor updates are ordered against translation.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
   parameter int unsigned PMU_PPN_W = 8;
   parameter int unsigned PMU_KEY_W = 4;

   typedef struct packed {
      logic [PMU_PPN_W-1:0] ppn;
      logic [PMU_KEY_W-1:0] lock;
      logic                 wprot;
   } pmu_desc_t;
endpackage

// File: rtl/pmu_desc_table.sv
`timescale 1ns/1ps
module pmu_desc_table
   import pmu_pkg::*;
#(
   parameter int unsigned GRP_W = 4,
   parameter int unsigned IDX_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [GRP_W+IDX_W-1:0] wr_sel,
   input  pmu_desc_t              wr_data,
   input  logic [GRP_W+IDX_W-1:0] rd_sel,
   output pmu_desc_t              rd_data
);
   localparam int unsigned SEL_W = GRP_W + IDX_W;
   localparam int unsigned N_ENT = 1 << SEL_W;

   pmu_desc_t entries [N_ENT];

   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            entries[e] <= '0;
         end else if (wr_en && (wr_sel == SEL_W'(e))) begin
            entries[e] <= wr_data;
         end
      end
   end

   assign rd_data = entries[rd_sel];

   // A load must be visible at its slot from the next cycle on (R9)
   assert_load_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (rd_sel == wr_sel)) |=> ($past(rd_sel) != rd_sel) || (rd_data == $past(wr_data)));
endmodule

// File: rtl/pmu_access_check.sv
`timescale 1ns/1ps
module pmu_access_check
   import pmu_pkg::*;
#(
   parameter bit WP_EN = 1'b1
) (
   input  logic [PMU_KEY_W-1:0] key,
   input  pmu_desc_t            desc,
   input  logic                 is_write,
   output logic                 violation
);
   logic lock_miss;
   logic wp_hit;

   assign lock_miss = (key != desc.lock);

   if (WP_EN) begin : g_wp
      assign wp_hit = is_write & desc.wprot;
   end else begin : g_no_wp
      assign wp_hit = 1'b0;
   end

   assign violation = lock_miss | wp_hit;
endmodule

// File: rtl/pmu_xlate_stage.sv
`timescale 1ns/1ps
module pmu_xlate_stage #(
   parameter int unsigned PPN_W = 8,
   parameter int unsigned OFS_W = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [PPN_W-1:0]       in_ppn,
   input  logic [OFS_W-1:0]       in_ofs,
   input  logic                   in_viol,
   output logic                   out_valid,
   output logic [PPN_W+OFS_W-1:0] out_paddr,
   output logic                   out_err_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_paddr <= '0;
         out_err_n <= 1'b1;
      end else begin
         out_valid <= in_valid;
         out_err_n <= ~(in_valid & in_viol);
         if (in_valid) begin
            out_paddr <= {in_ppn, in_ofs};
         end
      end
   end

   assert_one_cycle_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_no_rsp_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_paddr[OFS_W-1:0] == $past(in_ofs)));
   assert_quiet_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> out_err_n);
endmodule

// File: rtl/page_map_unit.sv
`timescale 1ns/1ps
module page_map_unit
   import pmu_pkg::*;
#(
   parameter int unsigned LA_W  = 16,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned OFS_W = 12,
   parameter int unsigned GRP_W = 4,
   parameter int unsigned PPN_W = 8,
   parameter int unsigned KEY_W = 4,
   parameter bit          WP_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [LA_W-1:0]        req_addr,
   input  logic                   req_write,
   input  logic [KEY_W-1:0]       cpu_key,
   input  logic [GRP_W-1:0]       cpu_state,
   input  logic                   bus_own,
   input  logic                   cfg_we,
   input  logic [GRP_W-1:0]       cfg_bank,
   input  logic [IDX_W-1:0]       cfg_slot,
   input  logic [PPN_W-1:0]       cfg_page,
   input  logic [KEY_W-1:0]       cfg_lock,
   input  logic                   cfg_wprot,
   output logic                   rsp_valid,
   output logic [PPN_W+OFS_W-1:0] rsp_paddr,
   output logic                   prot_err_n,
   output logic                   stat_oe,
   output logic [KEY_W-1:0]       key_out,
   output logic [GRP_W-1:0]       state_out
);
   localparam int unsigned PA_W  = PPN_W + OFS_W;
   localparam int unsigned SEL_W = GRP_W + IDX_W;

   if (LA_W != IDX_W + OFS_W) begin : g_bad_split
      $error("logical width must equal slot plus offset width");
   end
   if (PPN_W != PMU_PPN_W || KEY_W != PMU_KEY_W) begin : g_bad_pkg
      $error("page or key width disagrees with the descriptor type");
   end
   if (PA_W < LA_W) begin : g_bad_pa
      $error("physical space smaller than logical space");
   end

   logic             cfg_priv;
   logic             tbl_we;
   pmu_desc_t        cfg_desc;
   pmu_desc_t        cur_desc;
   logic [SEL_W-1:0] rd_sel;
   logic [SEL_W-1:0] wr_sel;
   logic             viol;

   assign cfg_priv = (cpu_key == '0);
   assign tbl_we   = cfg_we & cfg_priv;
   assign wr_sel   = {cfg_bank, cfg_slot};
   assign rd_sel   = {cpu_state, req_addr[LA_W-1 -: IDX_W]};
   assign cfg_desc = '{ppn: cfg_page, lock: cfg_lock, wprot: cfg_wprot};

   pmu_desc_table #(.GRP_W(GRP_W), .IDX_W(IDX_W)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_we),
      .wr_sel  (wr_sel),
      .wr_data (cfg_desc),
      .rd_sel  (rd_sel),
      .rd_data (cur_desc)
   );

   pmu_access_check #(.WP_EN(WP_EN)) u_check (
      .key       (cpu_key),
      .desc      (cur_desc),
      .is_write  (req_write),
      .violation (viol)
   );

   pmu_xlate_stage #(.PPN_W(PPN_W), .OFS_W(OFS_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (req_valid),
      .in_ppn    (cur_desc.ppn),
      .in_ofs    (req_addr[OFS_W-1:0]),
      .in_viol   (viol),
      .out_valid (rsp_valid),
      .out_paddr (rsp_paddr),
      .out_err_n (prot_err_n)
   );

   assign stat_oe   = bus_own;
   assign key_out   = bus_own ? cpu_key   : '0;
   assign state_out = bus_own ? cpu_state : '0;

   assert_page_from_desc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_paddr[PA_W-1 -: PPN_W] == $past(cur_desc.ppn)));
   assert_lock_miss_faults_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (cur_desc.lock != cpu_key)) |=> !prot_err_n);
   assert_wprot_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && cur_desc.wprot && WP_EN) |=> !prot_err_n);
   assert_clean_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (cur_desc.lock == cpu_key) && !(req_write && cur_desc.wprot)) |=> prot_err_n);
endmodule

// File: tb/page_map_unit_bench.sv
`timescale 1ns/1ps
module page_map_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [3:0]  cpu_key = '0;
   logic [3:0]  cpu_state = '0;
   logic        bus_own = 1'b1;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_bank = '0;
   logic [3:0]  cfg_slot = '0;
   logic [7:0]  cfg_page = '0;
   logic [3:0]  cfg_lock = '0;
   logic        cfg_wprot = 1'b0;
   logic        rsp_valid;
   logic [19:0] rsp_paddr;
   logic        prot_err_n;
   logic        stat_oe;
   logic [3:0]  key_out;
   logic [3:0]  state_out;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   page_map_unit u_page_map_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .cpu_key(cpu_key), .cpu_state(cpu_state),
      .bus_own(bus_own), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_slot(cfg_slot),
      .cfg_page(cfg_page), .cfg_lock(cfg_lock), .cfg_wprot(cfg_wprot),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .prot_err_n(prot_err_n),
      .stat_oe(stat_oe), .key_out(key_out), .state_out(state_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic load(input logic [3:0] b, input logic [3:0] s, input logic [7:0] pg,
                       input logic [3:0] lk, input logic wp, input logic [3:0] key);
      @(negedge clk);
      cpu_key = key; cfg_bank = b; cfg_slot = s; cfg_page = pg;
      cfg_lock = lk; cfg_wprot = wp; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // issue one request; returns at the negedge after its response edge
   task automatic xlate(input logic [3:0] st, input logic [15:0] a, input logic wr,
                        input logic [3:0] key);
      @(negedge clk);
      cpu_state = st; req_addr = a; req_write = wr; cpu_key = key; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 valid low in reset", 32'(rsp_valid), 0);
      chk("R1 err high in reset", 32'(prot_err_n), 1);
      @(negedge clk); rst_n = 1'b1;
      xlate(4'd3, 16'hA123, 1'b0, 4'd0);
      chk("R1 identity-like map", 32'(rsp_paddr), 32'h00123);
      chk("R1 no fault after reset", 32'(prot_err_n), 1);
   endtask

   task automatic t_map;
      load(4'd2, 4'd5, 8'hC3, 4'd0, 1'b0, 4'd0);
      load(4'd7, 4'd5, 8'h1E, 4'd0, 1'b0, 4'd0);
      load(4'd2, 4'd6, 8'h6A, 4'd0, 1'b0, 4'd0);
      xlate(4'd2, 16'h5ABC, 1'b0, 4'd0);
      chk("R2 bank 2 slot 5", 32'(rsp_paddr), 32'hC3ABC);
      xlate(4'd7, 16'h5ABC, 1'b0, 4'd0);
      chk("R2 bank 7 slot 5", 32'(rsp_paddr), 32'h1EABC);
      xlate(4'd2, 16'h6ABC, 1'b0, 4'd0);
      chk("R2 bank 2 slot 6", 32'(rsp_paddr), 32'h6AABC);
      xlate(4'd2, 16'h5000, 1'b0, 4'd0);
      chk("R3 offset zeros", 32'(rsp_paddr), 32'hC3000);
      xlate(4'd2, 16'h5FFF, 1'b0, 4'd0);
      chk("R3 offset ones", 32'(rsp_paddr), 32'hC3FFF);
   endtask

   task automatic t_timing;
      xlate(4'd7, 16'h5555, 1'b0, 4'd0);
      chk("R4 strobe in response cycle", 32'(rsp_valid), 1);
      @(negedge clk);
      chk("R4 strobe drops when idle", 32'(rsp_valid), 0);
      chk("R4 address held", 32'(rsp_paddr), 32'h1E555);
   endtask

   task automatic t_key;
      load(4'd1, 4'd2, 8'h44, 4'd9, 1'b0, 4'd0);
      xlate(4'd1, 16'h2010, 1'b0, 4'd9);
      chk("R5 matching key no fault", 32'(prot_err_n), 1);
      xlate(4'd1, 16'h2010, 1'b0, 4'd0);
      chk("R5 key mismatch fault", 32'(prot_err_n), 0);
      chk("R5 address still produced", 32'(rsp_paddr), 32'h44010);
      @(negedge clk);
      chk("R7 fault released when idle", 32'(prot_err_n), 1);
   endtask

   task automatic t_wprot;
      load(4'd1, 4'd3, 8'h55, 4'd0, 1'b1, 4'd0);
      xlate(4'd1, 16'h3001, 1'b0, 4'd0);
      chk("R6 read of protected page ok", 32'(prot_err_n), 1);
      xlate(4'd1, 16'h3001, 1'b1, 4'd0);
      chk("R6 write to protected page faults", 32'(prot_err_n), 0);
      xlate(4'd1, 16'h2001, 1'b1, 4'd9);
      chk("R6 write to unprotected page ok", 32'(prot_err_n), 1);
   endtask

   task automatic t_unpriv;
      load(4'd4, 4'd0, 8'h77, 4'd0, 1'b0, 4'd3);
      xlate(4'd4, 16'h0123, 1'b0, 4'd0);
      chk("R8 unprivileged load ignored", 32'(rsp_paddr), 32'h00123);
      chk("R8 lock unchanged", 32'(prot_err_n), 1);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      cpu_key = 4'd0; cfg_bank = 4'd5; cfg_slot = 4'd1; cfg_page = 8'h99;
      cfg_lock = 4'd0; cfg_wprot = 1'b0; cfg_we = 1'b1;
      cpu_state = 4'd5; req_addr = 16'h1456; req_valid = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      chk("R9 same-cycle request sees old", 32'(rsp_paddr), 32'h00456);
      xlate(4'd5, 16'h1456, 1'b0, 4'd0);
      chk("R9 later request sees load", 32'(rsp_paddr), 32'h99456);
   endtask

   task automatic t_bus;
      @(negedge clk);
      bus_own = 1'b1; cpu_key = 4'hB; cpu_state = 4'h6;
      #1;
      chk("R10 enable follows ownership", 32'(stat_oe), 1);
      chk("R10 key repeated", 32'(key_out), 32'hB);
      chk("R10 state repeated", 32'(state_out), 32'h6);
      bus_own = 1'b0;
      #1;
      chk("R10 enable off", 32'(stat_oe), 0);
      chk("R10 key released", 32'(key_out), 0);
      chk("R10 state released", 32'(state_out), 0);
      bus_own = 1'b1; cpu_key = 4'd0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_map();
      t_timing();
      t_key();
      t_wprot();
      t_unpriv();
      t_same_cycle();
      t_bus();
      repeat (2) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule